// File: doc/BRIEF.md
# DRAM Row Retirement Sweep Sequencer

When a DRAM error is reported at one address, every page that lives in the same DRAM row must be taken out of service. This sequencer takes the reported error address and walks all 32 values of its 5-bit column field, starting at 0. For each column it builds an address from the reported one, with only the column field replaced. It sends that address to an external translator and waits for the answer. It then converts the translated address to a page frame number and asks an external page-status service about that page. When the page qualifies, it emits a one-cycle retire command.

Each column can end in one of three ways without a retire command: the translator reports an error, the page is invalid or offline, or the page is already poisoned. The number of retire commands in a sweep therefore depends on the data. The translator and the page-status paths are valid/ready handshakes. The sequencer holds each request stable until it is accepted, and keeps at most one request in flight on each path. It always raises ready on a response channel while it waits for that response, so it never applies back-pressure to a response.

Top module: `row_sweep_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `xreq_valid`, `xrsp_ready`, `pq_valid`, `ps_ready` and `retire_valid` are all 0.
- R2: A `start` pulse is taken only while idle, and the error address is captured at that moment. A `start` pulse or a change of `err_addr` during a sweep has no effect on the addresses requested.
- R3: One sweep issues exactly 32 translation requests. Their column fields (address bits 5:1) run 0, 1, ..., 31 in that order.
- R4: Every request address equals the captured error address with bits 5:1 replaced by the current column. All other bits are unchanged.
- R5: A new translation request is presented only after the response to the previous one has been taken. `xreq_valid` and `xreq_addr` hold steady until `xreq_ready`.
- R6: A translation response with `xrsp_err`=1 produces no page-status query for that column. The sweep moves on to the next column.
- R7: The page-status query carries the page frame number, which is the translated address shifted right by 12.
- R8: A status response with `ps_online`=0 produces no retire command.
- R9: A status response with `ps_poisoned`=1 produces no retire command.
- R10: A status response with `ps_online`=1 and `ps_poisoned`=0 produces a retire command in the next cycle. The command is a one-cycle `retire_valid` pulse with `retire_pfn` set to that page frame number.
- R11: After column 31 has been handled, `done` pulses for one cycle and the block returns to idle, with `busy` low in the following cycle.
- R12: `pq_valid` and `pq_pfn` hold steady until `pq_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sweep (taken only while idle) |
| err_addr | input | 28 | Reported DRAM error address |
| busy | output | 1 | High while a sweep is running |
| done | output | 1 | One-cycle pulse at the end of a sweep |
| xreq_valid | output | 1 | Translation request valid |
| xreq_ready | input | 1 | Translator accepts the request |
| xreq_addr | output | 28 | Address with the column substituted |
| xrsp_valid | input | 1 | Translation response valid |
| xrsp_ready | output | 1 | Sequencer takes the response |
| xrsp_err | input | 1 | Translation failed |
| xrsp_addr | input | 48 | Translated address |
| pq_valid | output | 1 | Page-status query valid |
| pq_ready | input | 1 | Status service accepts the query |
| pq_pfn | output | 36 | Page frame number queried |
| ps_valid | input | 1 | Status response valid |
| ps_ready | output | 1 | Sequencer takes the status |
| ps_online | input | 1 | Page is valid and online |
| ps_poisoned | input | 1 | Page is already poisoned |
| retire_valid | output | 1 | One-cycle retire command |
| retire_pfn | output | 36 | Page frame number to retire |

## Verification
The request after a `start` taken at a clock edge appears from the next edge onward. A response taken at an edge is followed by the query, or by the next request, one edge later. A qualifying status taken at an edge gives `retire_valid` exactly one edge later, and `done` follows the last column's outcome by one edge. The bench drives every handshake at the falling edge. It records which handshakes will complete at the coming rising edge, then judges the retire and done outputs at the next falling edge, where they must already be set. Each column's expected outcome, request address and page frame number are computed arithmetically in the bench. The sweeps cover mixed outcomes, all-good, all-error and back-pressure with response delays.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE        = 3'd0,
    ST_REQ         = 3'd1,
    ST_WAIT_XLATE  = 3'd2,
    ST_QUERY       = 3'd3,
    ST_WAIT_STATUS = 3'd4,
    ST_RETIRE      = 3'd5,
    ST_DONE        = 3'd6
  } rsq_state_e;

endpackage

// File: rtl/rsq_col_ctr.sv
module rsq_col_ctr #(
  parameter int COL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [COL_W-1:0] col,
  output logic             last
);
  localparam logic [COL_W-1:0] COL_MAX = {COL_W{1'b1}};

  logic [COL_W-1:0] col_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      col_q <= '0;
    else if (clear)  col_q <= '0;
    else if (step)   col_q <= col_q + 1'b1;
  end

  assign col  = col_q;
  assign last = (col_q == COL_MAX);
endmodule

// File: rtl/rsq_field_sub.sv
module rsq_field_sub #(
  parameter int ADDR_W  = 28,
  parameter int COL_LSB = 1,
  parameter int COL_W   = 5
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [COL_W-1:0]  col,
  output logic [ADDR_W-1:0] addr
);
  localparam int COL_MSB = COL_LSB + COL_W - 1;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    if (i >= COL_LSB && i <= COL_MSB) begin : g_col
      assign addr[i] = col[i-COL_LSB];
    end else begin : g_keep
      assign addr[i] = base[i];
    end
  end
endmodule

// File: rtl/rsq_page_gate.sv
module rsq_page_gate #(
  parameter int SYS_W      = 48,
  parameter int PAGE_SHIFT = 12,
  localparam int PFN_W     = SYS_W - PAGE_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SYS_W-1:0] sys_addr,
  input  logic             online,
  input  logic             poisoned,
  output logic [PFN_W-1:0] pfn,
  output logic             qualify
);
  logic [PFN_W-1:0] pfn_q;
  logic             unused_offset_bits;

  assign unused_offset_bits = ^sys_addr[PAGE_SHIFT-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)    pfn_q <= '0;
    else if (load) pfn_q <= sys_addr[SYS_W-1:PAGE_SHIFT];
  end

  assign pfn     = pfn_q;
  assign qualify = online & ~poisoned;
endmodule

// File: rtl/row_sweep_seq.sv
module row_sweep_seq #(
  parameter int ADDR_W     = 28,
  parameter int COL_LSB    = 1,
  parameter int COL_W      = 5,
  parameter int SYS_W      = 48,
  parameter int PAGE_SHIFT = 12,
  localparam int PFN_W     = SYS_W - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] err_addr,
  output logic              busy,
  output logic              done,
  output logic              xreq_valid,
  input  logic              xreq_ready,
  output logic [ADDR_W-1:0] xreq_addr,
  input  logic              xrsp_valid,
  output logic              xrsp_ready,
  input  logic              xrsp_err,
  input  logic [SYS_W-1:0]  xrsp_addr,
  output logic              pq_valid,
  input  logic              pq_ready,
  output logic [PFN_W-1:0]  pq_pfn,
  input  logic              ps_valid,
  output logic              ps_ready,
  input  logic              ps_online,
  input  logic              ps_poisoned,
  output logic              retire_valid,
  output logic [PFN_W-1:0]  retire_pfn
);
  import rsq_pkg::*;

  rsq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] base_q;
  logic [COL_W-1:0]  col;
  logic              col_last;
  logic              accept;
  logic              advance;
  logic              xlate_take;
  logic              xlate_ok;
  logic              stat_take;
  logic              qualify;
  logic [PFN_W-1:0]  pfn;

  assign accept     = (state_q == ST_IDLE) && start;
  assign xlate_take = (state_q == ST_WAIT_XLATE) && xrsp_valid;
  assign xlate_ok   = xlate_take && !xrsp_err;
  assign stat_take  = (state_q == ST_WAIT_STATUS) && ps_valid;

  // A column is finished on a translation error, a rejected page, or a retire.
  assign advance = (xlate_take && xrsp_err)
                 || (stat_take && !qualify)
                 || (state_q == ST_RETIRE);

  always_ff @(posedge clk) begin
    if (!rst_n)      base_q <= '0;
    else if (accept) base_q <= err_addr;
  end

  rsq_col_ctr #(.COL_W(COL_W)) u_col (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(accept),
    .step (advance && !col_last),
    .col  (col),
    .last (col_last)
  );

  rsq_field_sub #(.ADDR_W(ADDR_W), .COL_LSB(COL_LSB), .COL_W(COL_W)) u_sub (
    .base(base_q),
    .col (col),
    .addr(xreq_addr)
  );

  rsq_page_gate #(.SYS_W(SYS_W), .PAGE_SHIFT(PAGE_SHIFT)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (xlate_ok),
    .sys_addr(xrsp_addr),
    .online  (ps_online),
    .poisoned(ps_poisoned),
    .pfn     (pfn),
    .qualify (qualify)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:        if (start) state_d = ST_REQ;
      ST_REQ:         if (xreq_ready) state_d = ST_WAIT_XLATE;
      ST_WAIT_XLATE:  if (xrsp_valid) begin
                        if (!xrsp_err)     state_d = ST_QUERY;
                        else if (col_last) state_d = ST_DONE;
                        else               state_d = ST_REQ;
                      end
      ST_QUERY:       if (pq_ready) state_d = ST_WAIT_STATUS;
      ST_WAIT_STATUS: if (ps_valid) begin
                        if (qualify)       state_d = ST_RETIRE;
                        else if (col_last) state_d = ST_DONE;
                        else               state_d = ST_REQ;
                      end
      ST_RETIRE:      state_d = col_last ? ST_DONE : ST_REQ;
      ST_DONE:        state_d = ST_IDLE;
      default:        state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy         = (state_q != ST_IDLE);
  assign done         = (state_q == ST_DONE);
  assign xreq_valid   = (state_q == ST_REQ);
  assign xrsp_ready   = (state_q == ST_WAIT_XLATE);
  assign pq_valid     = (state_q == ST_QUERY);
  assign ps_ready     = (state_q == ST_WAIT_STATUS);
  assign retire_valid = (state_q == ST_RETIRE);
  assign pq_pfn       = pfn;
  assign retire_pfn   = pfn;
endmodule

// File: rtl/rsq_checker.sv
module rsq_checker #(
  parameter int ADDR_W  = 28,
  parameter int COL_LSB = 1,
  parameter int COL_W   = 5,
  parameter int PFN_W   = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] err_addr,
  input logic              busy,
  input logic              done,
  input logic              xreq_valid,
  input logic              xreq_ready,
  input logic [ADDR_W-1:0] xreq_addr,
  input logic              xrsp_valid,
  input logic              xrsp_ready,
  input logic              xrsp_err,
  input logic              pq_valid,
  input logic              pq_ready,
  input logic [PFN_W-1:0]  pq_pfn,
  input logic              ps_valid,
  input logic              ps_ready,
  input logic              ps_online,
  input logic              ps_poisoned,
  input logic              retire_valid
);
  localparam logic [ADDR_W-1:0] FMASK =
    {{(ADDR_W-COL_W){1'b0}}, {COL_W{1'b1}}} << COL_LSB;

  logic              outst_q;
  logic              skip_q;
  logic [ADDR_W-1:0] base_q;
  logic [COL_W-1:0]  cnt_q;
  logic              ps_take;

  assign ps_take = ps_valid && ps_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outst_q <= 1'b0;
      skip_q  <= 1'b0;
      base_q  <= '0;
      cnt_q   <= '0;
    end else begin
      if (start && !busy) begin
        base_q <= err_addr;
        cnt_q  <= '0;
      end
      if (xreq_valid && xreq_ready) begin
        outst_q <= 1'b1;
        skip_q  <= 1'b0;
        cnt_q   <= cnt_q + 1'b1;
      end
      if (xrsp_valid && xrsp_ready) begin
        outst_q <= 1'b0;
        skip_q  <= xrsp_err;
      end
    end
  end

  assert_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xreq_valid |-> xreq_addr[COL_LSB +: COL_W] == cnt_q);
  assert_field_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xreq_valid |-> ((xreq_addr ^ base_q) & ~FMASK) == '0);
  assert_one_outstanding_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xreq_valid |-> !outst_q);
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xreq_valid && !xreq_ready |=> xreq_valid && $stable(xreq_addr));
  assert_skip_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pq_valid |-> !skip_q);
  assert_offline_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ps_take && !ps_online |=> !retire_valid);
  assert_poisoned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ps_take && ps_poisoned |=> !retire_valid);
  assert_retire_due_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ps_take && ps_online && !ps_poisoned |=> retire_valid);
  assert_retire_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |=> !retire_valid);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  assert_query_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pq_valid && !pq_ready |=> pq_valid && $stable(pq_pfn));
endmodule

bind row_sweep_seq rsq_checker #(
  .ADDR_W(ADDR_W), .COL_LSB(COL_LSB), .COL_W(COL_W), .PFN_W(PFN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .err_addr(err_addr),
  .busy(busy), .done(done),
  .xreq_valid(xreq_valid), .xreq_ready(xreq_ready), .xreq_addr(xreq_addr),
  .xrsp_valid(xrsp_valid), .xrsp_ready(xrsp_ready), .xrsp_err(xrsp_err),
  .pq_valid(pq_valid), .pq_ready(pq_ready), .pq_pfn(pq_pfn),
  .ps_valid(ps_valid), .ps_ready(ps_ready), .ps_online(ps_online),
  .ps_poisoned(ps_poisoned), .retire_valid(retire_valid)
);

// File: tb/sim_row_sweep_seq.sv
`timescale 1ns/1ps
module sim_row_sweep_seq;
  localparam int AW = 28;
  localparam int SW = 48;
  localparam int PW = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] err_addr = '0;
  logic busy, done, xreq_valid, xrsp_ready, pq_valid, ps_ready, retire_valid;
  logic xreq_ready = 1'b0, xrsp_valid = 1'b0, xrsp_err = 1'b0;
  logic [SW-1:0] xrsp_addr = '0;
  logic pq_ready = 1'b0, ps_valid = 1'b0, ps_online = 1'b0, ps_poisoned = 1'b0;
  logic [AW-1:0] xreq_addr;
  logic [PW-1:0] pq_pfn, retire_pfn;

  always #5 clk = ~clk;

  row_sweep_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .err_addr(err_addr),
    .busy(busy), .done(done),
    .xreq_valid(xreq_valid), .xreq_ready(xreq_ready), .xreq_addr(xreq_addr),
    .xrsp_valid(xrsp_valid), .xrsp_ready(xrsp_ready), .xrsp_err(xrsp_err),
    .xrsp_addr(xrsp_addr),
    .pq_valid(pq_valid), .pq_ready(pq_ready), .pq_pfn(pq_pfn),
    .ps_valid(ps_valid), .ps_ready(ps_ready), .ps_online(ps_online),
    .ps_poisoned(ps_poisoned),
    .retire_valid(retire_valid), .retire_pfn(retire_pfn)
  );

  int n_chk = 0, n_err = 0;
  logic [AW-1:0] g_base = '0;
  int g_mode = 0, g_seed = 0, g_bp = 0;
  int req_idx = 0, retire_cnt = 0, done_cnt = 0, cyc = 0;
  logic running = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // outcome: 0 good, 1 translation error, 2 offline, 3 poisoned
  function automatic int kind(input int c);
    int v;
    case (g_mode)
      1: return 0;
      2: return 1;
      3: begin
           v = c % 4;
           return (v == 0) ? 1 : (v == 1) ? 2 : (v == 2) ? 3 : 0;
         end
      default: begin
           v = (c * 7 + g_seed) % 8;
           return (v < 2) ? 1 : (v == 2) ? 2 : (v == 3) ? 3 : 0;
         end
    endcase
  endfunction

  function automatic logic [AW-1:0] exp_req(input int c);
    return (g_base & ~28'h3E) | (AW'(c) << 1);
  endfunction

  function automatic logic [SW-1:0] sys_of(input int c);
    return (SW'(exp_req(c)) * 48'd40503) + SW'(g_seed * 4099);
  endfunction

  function automatic logic [PW-1:0] pfn_of(input int c);
    logic [SW-1:0] s;
    s = sys_of(c);
    return s[SW-1:12];
  endfunction

  // responders: act at the falling edge on handshakes recorded one edge earlier
  int x_col = 0, x_dly = 0, q_col = 0, s_col = 0, s_dly = 0, stat_col = 0;
  bit x_pend = 0, s_pend = 0, xr_hs = 0, st_hs = 0;

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (running && retire_valid) begin
        retire_cnt++;
        chk(kind(stat_col) == 0, "R8/R9 retire only for good page", kind(stat_col), 0);
        chk(retire_pfn == pfn_of(stat_col), "R10 retire pfn", retire_pfn, pfn_of(stat_col));
      end
      if (running && done) begin
        done_cnt++;
        chk(req_idx == 32, "R11 done after column 31", req_idx, 32);
      end
      if (xr_hs) xrsp_valid = 1'b0;
      if (st_hs) ps_valid = 1'b0;
      if (x_pend && !xrsp_valid) begin
        if (x_dly == 0) begin
          xrsp_valid = 1'b1;
          xrsp_err   = (kind(x_col) == 1);
          xrsp_addr  = sys_of(x_col);
          x_pend     = 0;
        end else x_dly--;
      end
      if (s_pend && !ps_valid) begin
        if (s_dly == 0) begin
          ps_valid    = 1'b1;
          ps_online   = (kind(s_col) != 2);
          ps_poisoned = (kind(s_col) == 3);
          s_pend      = 0;
        end else s_dly--;
      end
      xreq_ready = (g_bp == 0) || ((cyc % 3) != 0);
      pq_ready   = (g_bp == 0) || ((cyc % 4) != 1);
      xr_hs = xrsp_valid && xrsp_ready;
      if (xr_hs) q_col = x_col;
      if (xreq_valid && xreq_ready) begin
        chk(!x_pend && !xrsp_valid, "R5 single outstanding request", x_pend, 0);
        chk(xreq_addr[5:1] == 5'(req_idx), "R3 column order", xreq_addr[5:1], req_idx);
        chk(xreq_addr == exp_req(req_idx), "R2/R4 request address", xreq_addr, exp_req(req_idx));
        x_col  = req_idx;
        x_dly  = (g_bp != 0) ? (req_idx % 3) : 0;
        x_pend = 1;
        req_idx++;
      end
      if (pq_valid && pq_ready) begin
        chk(kind(q_col) != 1, "R6 no query after translation error", kind(q_col), 0);
        chk(pq_pfn == pfn_of(q_col), "R7 query pfn", pq_pfn, pfn_of(q_col));
        s_col  = q_col;
        s_dly  = (g_bp != 0) ? (q_col % 2) : 0;
        s_pend = 1;
      end
      st_hs = ps_valid && ps_ready;
      if (st_hs) stat_col = s_col;
    end
  end

  task automatic sweep(input logic [AW-1:0] base, input int mode, input int seed,
                       input int bp, input bit stray);
    int exp_ret, n;
    g_base = base; g_mode = mode; g_seed = seed; g_bp = bp;
    req_idx = 0; retire_cnt = 0; done_cnt = 0;
    exp_ret = 0;
    for (int c = 0; c < 32; c++) if (kind(c) == 0) exp_ret++;
    running = 1'b1;
    @(negedge clk); start = 1'b1; err_addr = base;
    @(negedge clk); start = 1'b0; err_addr = ~base;
    n = 0;
    while (done_cnt == 0 && n < 20000) begin
      @(negedge clk); n++;
      if (stray && n == 40) begin start = 1'b1; err_addr = 28'h1234567; end
      if (stray && n == 41) start = 1'b0;
    end
    chk(n < 20000, "R11 watchdog sweep finished", n, 20000);
    repeat (6) @(negedge clk);
    chk(req_idx == 32, "R3 request count", req_idx, 32);
    chk(done_cnt == 1, "R11 single done pulse", done_cnt, 1);
    chk(!busy, "R11 idle after done", busy, 0);
    chk(retire_cnt == exp_ret, "R8/R9/R10 retire count", retire_cnt, exp_ret);
    running = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !xreq_valid && !xrsp_ready, "R1 reset outputs a", busy, 0);
    chk(!pq_valid && !ps_ready && !retire_valid, "R1 reset outputs b", retire_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !xreq_valid, "R1 idle after reset", busy, 0);
    sweep(28'hABCDEF1, 0, 1, 0, 0);
    sweep(28'hFFFFFFF, 1, 2, 1, 0);
    sweep(28'h0000000, 2, 3, 1, 0);
    sweep(28'h5A5A5A5, 0, 5, 1, 1);
    sweep(28'h3C3C3C0, 3, 7, 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule